// File: doc/BRIEF.md
# Bank-Switched Register File

This block is the register file of a small CPU core. It offers 64 register locations through a port indexed by a 6-bit register number. The lowest eight locations have no storage of their own. They are a window onto one of four eight-byte banks. Those banks occupy the bottom 32 bytes of on-chip RAM, so a second port, addressed by byte address, can reach them as plain memory. A 2-bit bank select, taken from the processor status word, chooses which bank the window shows. Changing it gives a fast context switch, because no register contents need to be copied.

Register numbers 8 to 31 and 56 to 63 are held in separate core storage and do not depend on the bank select. Numbers 32 to 55 are a reserved hole. An access there raises an error flag, reads zero and changes nothing. The memory port only serves the banked area. It flags every other address as not handled, and that address belongs to general RAM elsewhere. Both ports write on the clock edge and read combinationally. When both ports write the same byte in the same cycle, the register-port write takes effect.

Top module: `regbank_file`

## Requirements
- R1: While reset is high and on the first cycle after it, the bank select in use is 0: register numbers 0–7 read memory bytes 00H–07H whatever the bank_sel input is.
- R2: With bank select value s in use, register number i (0–7) reads and writes memory byte s*8+i (00→00H–07H, 01→08H–0FH, 10→10H–17H, 11→18H–1FH).
- R3: The memory port reads and writes every byte 00H–1FH under any bank select, with mem_hit high.
- R4: For a memory address of 20H or above, mem_hit is low and mem_rdata is zero. A write there changes no byte of the banked area.
- R5: Register numbers 8–31 and 56–63 keep their values across bank select changes and do not alias any memory byte 00H–1FH.
- R6: For register numbers 32–55, rf_err is high and rf_rdata is zero. A write there changes no other register location.
- R7: A write through either port is seen through the other port in the next cycle.
- R8: If both ports write the same byte in one cycle, the value written through the register port is the one kept.
- R9: A new bank_sel value is used for register-port accesses from the clock cycle after the edge that samples it. In the cycle it is applied, the old bank is still shown.
- R10: rf_err is low for every register number outside 32–55.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 2 | Bank select from the status word |
| rf_idx | input | 6 | Register number for the register port |
| rf_we | input | 1 | Register-port write enable |
| rf_wdata | input | 8 | Register-port write data |
| rf_rdata | output | 8 | Register-port read data (combinational) |
| rf_err | output | 1 | Register number lies in the reserved hole |
| mem_addr | input | 16 | Memory-port byte address |
| mem_we | input | 1 | Memory-port write enable |
| mem_wdata | input | 8 | Memory-port write data |
| mem_rdata | output | 8 | Memory-port read data, zero when not handled |
| mem_hit | output | 1 | Address lies in the banked area 00H–1FH |

## Verification
The hardest case to reach is the same-cycle collision, where a register-port write and a memory-port write land on one physical byte. It only occurs when the memory address equals the bank select times eight plus the low register bits. The stimulus first sets a non-zero bank and lets it take effect, then drives both writes in one cycle at that computed address. The bench then reads the byte back through both ports. The one-cycle lag of the bank select is reached by changing bank_sel and sampling the register port before the next edge, then again after it.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_BANK = 4;
  localparam int BANK_SZ  = 8;
  localparam int RF_AW    = 6;
  localparam int MEM_AW   = 16;
  localparam int RSV_LO   = 32;
  localparam int RSV_HI   = 56;

  typedef enum logic [1:0] {
    REG_BANKED = 2'd0,
    REG_CORE   = 2'd1,
    REG_RSV    = 2'd2
  } reg_region_e;
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int RAW    = RF_AW,
  parameter int BSZ    = BANK_SZ,
  parameter int NBANK  = NUM_BANK,
  parameter int LO_RSV = RSV_LO,
  parameter int HI_RSV = RSV_HI,
  localparam int SEL_W  = $clog2(NBANK),
  localparam int BANK_AW = $clog2(BSZ),
  localparam int RAM_AW = SEL_W + BANK_AW,
  localparam int CORE_DEPTH = (LO_RSV - BSZ) + ((1 << RAW) - HI_RSV),
  localparam int CORE_AW = $clog2(CORE_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RAW-1:0]     idx,
  input  logic [SEL_W-1:0]   bank_q,
  output reg_region_e        region,
  output logic [RAM_AW-1:0]  phys_addr,
  output logic [CORE_AW-1:0] core_slot
);
  logic [RAW:0] idx_w;
  logic [RAW:0] slot_w;

  always_comb begin
    idx_w = {1'b0, idx};
    if (idx_w < (RAW+1)'(BSZ))
      region = REG_BANKED;
    else if (idx_w < (RAW+1)'(LO_RSV) || idx_w >= (RAW+1)'(HI_RSV))
      region = REG_CORE;
    else
      region = REG_RSV;

    if (idx_w < (RAW+1)'(LO_RSV))
      slot_w = idx_w - (RAW+1)'(BSZ);
    else
      slot_w = idx_w - (RAW+1)'(HI_RSV - LO_RSV + BSZ);
  end

  assign core_slot = slot_w[CORE_AW-1:0];
  assign phys_addr = {bank_q, idx[BANK_AW-1:0]};

  // R5: a core location never maps beyond the core storage
  assert_slot_range_R5: assert property (@(posedge clk) disable iff (rst)
    (region == REG_CORE) |-> (slot_w < (RAW+1)'(CORE_DEPTH)));
endmodule

// File: rtl/regbank_ram.sv
module regbank_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  // port a written last so it wins on a shared address
  always_ff @(posedge clk) begin
    if (b_we) mem_q[b_addr] <= b_wdata;
    if (a_we) mem_q[a_addr] <= a_wdata;
  end

  assign a_rdata = mem_q[a_addr];
  assign b_rdata = mem_q[b_addr];

  // R8: a same-address collision keeps the register-port data
  assert_collision_a_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (a_we && b_we && a_addr == b_addr) |=> (mem_q[$past(a_addr)] == $past(a_wdata)));

  // R7: a memory-port write is stored for the other port to see
  assert_b_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
    (b_we && !(a_we && a_addr == b_addr)) |=> (mem_q[$past(b_addr)] == $past(b_wdata)));
endmodule

// File: rtl/regbank_core.sv
module regbank_core #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[addr] <= wdata;
  end

  assign rdata = store_q[addr];
endmodule

// File: rtl/regbank_file.sv
module regbank_file
  import regbank_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int NBANK  = NUM_BANK,
  parameter int BSZ    = BANK_SZ,
  parameter int RAW    = RF_AW,
  parameter int MAW    = MEM_AW,
  parameter int LO_RSV = RSV_LO,
  parameter int HI_RSV = RSV_HI,
  localparam int SEL_W  = $clog2(NBANK),
  localparam int RAM_DEPTH = NBANK * BSZ,
  localparam int RAM_AW = $clog2(RAM_DEPTH),
  localparam int CORE_DEPTH = (LO_RSV - BSZ) + ((1 << RAW) - HI_RSV),
  localparam int CORE_AW = $clog2(CORE_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] bank_sel,
  input  logic [RAW-1:0]   rf_idx,
  input  logic             rf_we,
  input  logic [DW-1:0]    rf_wdata,
  output logic [DW-1:0]    rf_rdata,
  output logic             rf_err,
  input  logic [MAW-1:0]   mem_addr,
  input  logic             mem_we,
  input  logic [DW-1:0]    mem_wdata,
  output logic [DW-1:0]    mem_rdata,
  output logic             mem_hit
);
  logic [SEL_W-1:0]   bank_q;
  reg_region_e        region;
  logic [RAM_AW-1:0]  phys_addr;
  logic [CORE_AW-1:0] core_slot;
  logic [DW-1:0]      ram_rf_rdata;
  logic [DW-1:0]      ram_mem_rdata;
  logic [DW-1:0]      core_rdata;
  logic               ram_rf_we;
  logic               core_we;
  logic               ram_mem_we;

  // bank select is sampled so a change applies from the next cycle
  always_ff @(posedge clk) begin
    if (rst) bank_q <= '0;
    else     bank_q <= bank_sel;
  end

  regbank_decode #(
    .RAW(RAW), .BSZ(BSZ), .NBANK(NBANK), .LO_RSV(LO_RSV), .HI_RSV(HI_RSV)
  ) u_decode (
    .clk(clk), .rst(rst), .idx(rf_idx), .bank_q(bank_q),
    .region(region), .phys_addr(phys_addr), .core_slot(core_slot)
  );

  assign ram_rf_we  = rf_we && (region == REG_BANKED);
  assign core_we    = rf_we && (region == REG_CORE);
  assign mem_hit    = (mem_addr < MAW'(RAM_DEPTH));
  assign ram_mem_we = mem_we && mem_hit;

  regbank_ram #(.DW(DW), .DEPTH(RAM_DEPTH)) u_ram (
    .clk(clk), .rst(rst),
    .a_we(ram_rf_we), .a_addr(phys_addr), .a_wdata(rf_wdata), .a_rdata(ram_rf_rdata),
    .b_we(ram_mem_we), .b_addr(mem_addr[RAM_AW-1:0]), .b_wdata(mem_wdata),
    .b_rdata(ram_mem_rdata)
  );

  regbank_core #(.DW(DW), .DEPTH(CORE_DEPTH)) u_core (
    .clk(clk), .we(core_we), .addr(core_slot), .wdata(rf_wdata), .rdata(core_rdata)
  );

  always_comb begin
    case (region)
      REG_BANKED: rf_rdata = ram_rf_rdata;
      REG_CORE:   rf_rdata = core_rdata;
      default:    rf_rdata = '0;
    endcase
  end

  assign rf_err    = (region == REG_RSV);
  assign mem_rdata = mem_hit ? ram_mem_rdata : '0;

  // R6: reserved locations read as zero
  assert_rsv_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
    rf_err |-> (rf_rdata == '0));

  // R10: the error flag only covers the reserved hole
  assert_err_only_reserved_R10: assert property (@(posedge clk) disable iff (rst)
    rf_err |-> (rf_idx >= RAW'(LO_RSV) && rf_idx < RAW'(HI_RSV)));

  // R4: unhandled memory addresses return zero
  assert_miss_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_hit |-> (mem_rdata == '0));

  // R3: the banked window is always handled
  assert_window_hit_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_addr < MAW'(RAM_DEPTH)) |-> mem_hit);

  // R9: the bank in use follows the select input one cycle later
  assert_bank_lag_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(bank_sel) |=> (phys_addr[RAM_AW-1 -: SEL_W] == $past(bank_sel) || rst));
endmodule

// File: tb/test_regbank_file.sv
module test_regbank_file;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] bank_sel;
  logic [5:0] rf_idx;
  logic       rf_we;
  logic [7:0] rf_wdata;
  logic [7:0] rf_rdata;
  logic       rf_err;
  logic [15:0] mem_addr;
  logic       mem_we;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata;
  logic       mem_hit;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] ref_ram [32];

  always #5ns clk = ~clk;

  regbank_file i_regbank_file (
    .clk(clk), .rst(rst), .bank_sel(bank_sel),
    .rf_idx(rf_idx), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .rf_err(rf_err),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_hit(mem_hit)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at the falling edge, let the next rising edge commit
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    rf_we = 1'b0;
    mem_we = 1'b0;
  endtask

  task automatic mem_wr(input logic [15:0] a, input logic [7:0] d);
    mem_addr = a; mem_wdata = d; mem_we = 1'b1;
    step();
  endtask

  task automatic rf_wr(input logic [5:0] i, input logic [7:0] d);
    rf_idx = i; rf_wdata = d; rf_we = 1'b1;
    step();
  endtask

  task automatic set_bank(input logic [1:0] s);
    bank_sel = s;
    step();
  endtask

  task automatic t_reset_R1();
    rst = 1'b1; bank_sel = 2'd2; rf_we = 0; mem_we = 0; rf_idx = 0; rf_wdata = 0;
    mem_addr = 0; mem_wdata = 0;
    @(negedge clk);
    mem_wr(16'h0003, 8'hA5);
    mem_wr(16'h0013, 8'h5A);
    rf_idx = 6'd3; #1;
    chk("R1 reset bank 0 shown", rf_rdata, 8'hA5);
    chk("R1 reset no error", rf_err, 1'b0);
    for (int a = 0; a < 32; a++) begin
      ref_ram[a] = 8'h40 + 8'(a);
      mem_wr(16'(a), ref_ram[a]);
    end
    bank_sel = 2'd0;
    rst = 1'b0;
    rf_idx = 6'd3; #1;
    chk("R1 first cycle after reset bank 0", rf_rdata, ref_ram[3]);
  endtask

  task automatic t_window_R3();
    for (int s = 0; s < 4; s++) begin
      set_bank(2'(s));
      for (int a = 0; a < 32; a += 5) begin
        mem_addr = 16'(a); #1;
        chk("R3 window read", mem_rdata, ref_ram[a]);
        chk("R3 window hit", mem_hit, 1'b1);
      end
    end
    mem_addr = 16'h001F; #1;
    chk("R3 top byte hit", mem_hit, 1'b1);
  endtask

  task automatic t_bank_map_R2();
    for (int s = 0; s < 4; s++) begin
      set_bank(2'(s));
      for (int i = 0; i < 8; i++) begin
        rf_idx = 6'(i); #1;
        chk("R2 bank map read", rf_rdata, ref_ram[s*8+i]);
      end
    end
  endtask

  task automatic t_outside_R4();
    for (int k = 0; k < 4; k++) begin
      mem_addr = 16'h0020 + 16'(k); #1;
      chk("R4 miss flag", mem_hit, 1'b0);
      chk("R4 miss reads zero", mem_rdata, 8'h00);
      mem_wr(16'h0020 + 16'(k), 8'hEE);
      mem_addr = 16'(k); #1;
      chk("R4 write outside ignored", mem_rdata, ref_ram[k]);
    end
    mem_wr(16'h0105, 8'hEE);
    mem_addr = 16'h0105; #1;
    chk("R4 high address miss", mem_hit, 1'b0);
    mem_addr = 16'h0005; #1;
    chk("R4 high address no alias", mem_rdata, ref_ram[5]);
  endtask

  task automatic t_core_R5();
    set_bank(2'd1);
    rf_wr(6'd8, 8'h81);
    rf_wr(6'd31, 8'h9F);
    rf_wr(6'd56, 8'hB8);
    rf_wr(6'd63, 8'hBF);
    set_bank(2'd3);
    rf_idx = 6'd8;  #1; chk("R5 core loc 8", rf_rdata, 8'h81);
    rf_idx = 6'd31; #1; chk("R5 core loc 31", rf_rdata, 8'h9F);
    rf_idx = 6'd56; #1; chk("R5 core loc 56", rf_rdata, 8'hB8);
    rf_idx = 6'd63; #1; chk("R5 core loc 63", rf_rdata, 8'hBF);
    rf_idx = 6'd20; #1; chk("R10 no error at 20", rf_err, 1'b0);
    mem_addr = 16'h0008; #1; chk("R5 no alias to 08H", mem_rdata, ref_ram[8]);
    mem_addr = 16'h001F; #1; chk("R5 no alias to 1FH", mem_rdata, ref_ram[31]);
  endtask

  task automatic t_reserved_R6();
    rf_idx = 6'd32; #1;
    chk("R6 error at 32", rf_err, 1'b1);
    chk("R6 zero at 32", rf_rdata, 8'h00);
    rf_idx = 6'd55; #1;
    chk("R6 error at 55", rf_err, 1'b1);
    rf_wr(6'd32, 8'h77);
    rf_wr(6'd40, 8'h77);
    rf_wr(6'd55, 8'h77);
    rf_idx = 6'd40; #1; chk("R6 zero after write", rf_rdata, 8'h00);
    rf_idx = 6'd31; #1; chk("R6 neighbour 31 kept", rf_rdata, 8'h9F);
    chk("R10 no error at 31", rf_err, 1'b0);
    rf_idx = 6'd56; #1; chk("R6 neighbour 56 kept", rf_rdata, 8'hB8);
    chk("R10 no error at 56", rf_err, 1'b0);
    rf_idx = 6'd7; #1; chk("R10 no error at 7", rf_err, 1'b0);
    chk("R6 banked byte kept", rf_rdata, ref_ram[3*8+7]);
  endtask

  task automatic t_cross_R7();
    set_bank(2'd2);
    rf_wr(6'd5, 8'h3C); ref_ram[16+5] = 8'h3C;
    mem_addr = 16'h0015; #1;
    chk("R7 register write seen by memory", mem_rdata, 8'h3C);
    mem_wr(16'h0016, 8'hC3); ref_ram[16+6] = 8'hC3;
    rf_idx = 6'd6; #1;
    chk("R7 memory write seen by register", rf_rdata, 8'hC3);
  endtask

  task automatic t_collision_R8();
    set_bank(2'd1);
    rf_idx = 6'd2; rf_wdata = 8'h11; rf_we = 1'b1;
    mem_addr = 16'h000A; mem_wdata = 8'h22; mem_we = 1'b1;
    step(); ref_ram[10] = 8'h11;
    rf_idx = 6'd2; mem_addr = 16'h000A; #1;
    chk("R8 register port wins (rf)", rf_rdata, 8'h11);
    chk("R8 register port wins (mem)", mem_rdata, 8'h11);
  endtask

  task automatic t_switch_R9();
    bank_sel = 2'd3; rf_idx = 6'd0; #1;
    chk("R9 old bank still shown", rf_rdata, ref_ram[8]);
    step();
    rf_idx = 6'd0; #1;
    chk("R9 new bank after edge", rf_rdata, ref_ram[24]);
    bank_sel = 2'd0; rf_idx = 6'd4; rf_wdata = 8'hD4; rf_we = 1'b1;
    step(); ref_ram[28] = 8'hD4;
    mem_addr = 16'h001C; #1;
    chk("R9 write uses bank in use", mem_rdata, 8'hD4);
    mem_addr = 16'h0004; #1;
    chk("R9 new bank not yet written", mem_rdata, ref_ram[4]);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset_R1();
    t_window_R3();
    t_bank_map_R2();
    t_outside_R4();
    t_core_R5();
    t_reserved_R6();
    t_cross_R7();
    t_collision_R8();
    t_switch_R9();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule